// File: doc/BRIEF.md
# Prefixed Opcode Decoder with Cycle Costs

This block takes an 8-bit instruction stream, one byte per transfer. It works out where each instruction starts and ends within a small subset of an 8-bit processor's instruction set. For each instruction it reports what kind of operation it is, which registers it names, and two numbers: how many bytes it took and how many clock cycles the processor spends on it. Bytes arrive over a valid/ready channel. The result leaves over a second valid/ready channel that holds one result.

Three prefix bytes change how the bytes after them are read. A bit-test prefix opens the bit-test page. An extended prefix opens the 16-bit add-with-carry page. An index prefix picks one of two index registers. Under the index prefix, a memory-through-hl operand becomes index plus a signed 8-bit displacement, and the 16-bit add works on the index register. Any byte that cannot continue the instruction so far ends it at once as illegal, and the decoder then expects a new first byte.

Back-pressure: `in_ready` is low only while a result is waiting and `out_ready` is low. A byte transfers on a rising edge where `in_valid` and `in_ready` are both high. A result stays on the output pins, unchanged, until it is taken. Because `in_ready` also follows `out_ready`, a new instruction can finish in the same cycle that the previous result is taken.

Top module: `insn_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A byte 10ggg rrr with ggg=000 (add), 001 (add with carry) or 100 (AND) gives class 0, 1 or 2. It has `out_dst`=111 (accumulator), `out_src`=rrr, length 1, and costs 4 cycles, or 7 cycles when rrr=110 (memory through hl). The register codes are a=111, b=000, c=001, d=010, e=011, h=100, l=101.
- R3: The bytes 0xC6, 0xCE and 0xE6 (add, add with carry, AND) each take one data byte. They give class 0, 1 or 2 with `out_dst`=111 and `out_src`=000. The data byte appears in `out_data[7:0]` with `out_data[15:8]`=0. Length is 2 and cost is 7.
- R4: Prefix 0xDD selects the first index register (`out_iy`=0) and 0xFD the second (`out_iy`=1). After a prefix, an R2 opcode with rrr=110 takes a displacement byte, shown on `out_disp`, and reports `out_indexed`=1, length 3 and cost 19.
- R5: Bit test is the prefix 0xCB followed by 01bbbrrr. It gives class 3, `out_bit`=bbb and `out_src`=rrr, with length 2. It costs 8, or 12 when rrr=110. The indexed form is index prefix, 0xCB, displacement, then 01bbb110. It has length 4 and costs 20.
- R6: The 16-bit add 00qq1001 gives class 4 with `out_pair`=qq (00 bc, 01 de, 10 hl, 11 sp), length 1 and cost 11. With an index prefix it reports `out_indexed`=1, length 2 and cost 15, and pair 10 then names the index register.
- R7: 0xED followed by 01qq1010 gives class 5 (16-bit add with carry into hl) with `out_pair`=qq, length 2 and cost 15.
- R8: 01ddd sss gives class 6 (register copy) with `out_dst`=ddd, `out_src`=sss, length 1 and cost 4. If either field is 110, the byte is illegal.
- R9: 11pp0101 is push (class 7, cost 11) and 11pp0001 is pop (class 8, cost 10). For both, `out_pair`=pp, where 11 names af. 0xC9 is return (class 10, cost 10) and 0x3F is complement-carry (class 11, cost 4). Each has length 1.
- R10: 0xCD followed by a low and then a high address byte gives class 9, `out_data`={high,low}, length 3 and cost 17.
- R11: A byte that cannot extend the instruction so far produces a result at once. The result has `out_illegal`=1, class 15, cost 0 and all other fields 0, and its length counts the bytes taken including the offending one. This applies to a second prefix, an index prefix before any opcode other than a memory-operand ALU op, a 16-bit add or a bit test, 0xED before anything but 01qq1010, and 0xCB before a byte outside 01xxxxxx. The next byte is then decoded as a first byte.
- R12: A result appears on `out_valid` the cycle after its final byte transfers. It stays stable while `out_ready` is low. `in_ready` is low exactly when `out_valid` is 1 and `out_ready` is 0.
- R13: Any of `out_dst`, `out_src`, `out_pair`, `out_bit`, `out_disp`, `out_data`, `out_indexed` and `out_iy` that the class does not use reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_illegal | output | 1 | Sequence outside the subset |
| out_class | output | 4 | Operation class code |
| out_dst | output | 3 | Destination register code |
| out_src | output | 3 | Source register code (110 = memory operand) |
| out_pair | output | 2 | Register pair code |
| out_indexed | output | 1 | Index prefix in effect |
| out_iy | output | 1 | Second index register selected |
| out_bit | output | 3 | Bit number for bit test |
| out_len | output | 3 | Instruction length in bytes |
| out_cycles | output | 5 | Documented clock-cycle cost |
| out_disp | output | 8 | Signed displacement byte |
| out_data | output | 16 | Immediate byte or call address |

## Verification
The bench feeds the indexed bit test, where the displacement comes before the opcode byte. A decoder that read those two bytes in the wrong order would report the wrong bit number and displacement, and would flag valid sequences as illegal. Illegal cases end at the first or second byte, for example a double prefix, a prefix before a return, or an extended prefix before a byte outside its page. A decoder that kept its prefix state, or mis-counted the bytes taken, would then get the next instruction's length and class wrong. Complement-carry and register copies with a 110 field are also checked, since they share bit patterns with the 16-bit add and the memory forms. Under random back-pressure, a decoder that overwrote a waiting result or dropped a byte would break the stability check or the order of results.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;
  localparam int CYC_W  = 5;
  localparam int DATA_W = 2 * BYTE_W;

  localparam logic [CYC_W-1:0] CY_ALU_REG = 5'd4;
  localparam logic [CYC_W-1:0] CY_ALU_MEM = 5'd7;
  localparam logic [CYC_W-1:0] CY_ALU_IDX = 5'd19;
  localparam logic [CYC_W-1:0] CY_BIT_REG = 5'd8;
  localparam logic [CYC_W-1:0] CY_BIT_MEM = 5'd12;
  localparam logic [CYC_W-1:0] CY_BIT_IDX = 5'd20;
  localparam logic [CYC_W-1:0] CY_W16     = 5'd11;
  localparam logic [CYC_W-1:0] CY_W16_IDX = 5'd15;
  localparam logic [CYC_W-1:0] CY_CALL    = 5'd17;
  localparam logic [CYC_W-1:0] CY_PUSH    = 5'd11;
  localparam logic [CYC_W-1:0] CY_POPRET  = 5'd10;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_AND = 4'd2, OP_BIT = 4'd3,
    OP_ADD16 = 4'd4, OP_ADC16 = 4'd5, OP_LD = 4'd6, OP_PUSH = 4'd7,
    OP_POP = 4'd8, OP_CALL = 4'd9, OP_RET = 4'd10, OP_CCF = 4'd11,
    OP_ILL = 4'd15
  } op_class_e;

  typedef enum logic [1:0] {FM_REG, FM_MEM, FM_IMM, FM_IDX} form_e;
  typedef enum logic [1:0] {PG_MAIN, PG_BIT, PG_EXT} page_e;
  typedef enum logic [1:0] {ND_NONE, ND_DISP, ND_IMM, ND_ADDR} need_e;

  typedef enum logic [3:0] {
    ST_OP, ST_XOP, ST_BIT, ST_XDISPB, ST_XBIT, ST_EXT,
    ST_DISP, ST_IMM, ST_ALO, ST_AHI
  } state_e;

  typedef struct packed {
    op_class_e  cls;
    form_e      form;
    logic [2:0] dst;
    logic [2:0] src;
    logic [1:0] pair;
    logic [2:0] bitn;
  } fields_t;

  typedef struct packed {
    logic              ill;
    op_class_e         cls;
    logic [2:0]        dst;
    logic [2:0]        src;
    logic [1:0]        pair;
    logic              ix;
    logic              iy;
    logic [2:0]        bitn;
    logic [LEN_W-1:0]  len;
    logic [CYC_W-1:0]  cyc;
    logic [BYTE_W-1:0] disp;
    logic [DATA_W-1:0] data;
  } result_t;
endpackage

// File: rtl/idec_classify.sv
module idec_classify
  import idec_pkg::*;
(
  input  page_e             page,
  input  logic              indexed,
  input  logic [BYTE_W-1:0] code,
  output fields_t           f,
  output need_e             need,
  output logic              is_idx_pfx,
  output logic              is_bit_pfx,
  output logic              is_ext_pfx,
  output logic              illegal
);
  function automatic logic alu_known(input logic [2:0] g);
    return (g == 3'd0) || (g == 3'd1) || (g == 3'd4);
  endfunction

  function automatic op_class_e alu_cls(input logic [2:0] g);
    case (g)
      3'd0:    return OP_ADD;
      3'd1:    return OP_ADC;
      default: return OP_AND;
    endcase
  endfunction

  logic hit;

  always_comb begin
    f          = '0;
    f.cls      = OP_ILL;
    need       = ND_NONE;
    is_idx_pfx = 1'b0;
    is_bit_pfx = 1'b0;
    is_ext_pfx = 1'b0;
    hit        = 1'b0;
    case (page)
      PG_MAIN: begin
        if (code == 8'hDD || code == 8'hFD) begin
          if (!indexed) begin
            is_idx_pfx = 1'b1;
            hit        = 1'b1;
          end
        end else if (code == 8'hCB) begin
          is_bit_pfx = 1'b1;
          hit        = 1'b1;
        end else if (code == 8'hED) begin
          if (!indexed) begin
            is_ext_pfx = 1'b1;
            hit        = 1'b1;
          end
        end else if (code[7:6] == 2'b10 && alu_known(code[5:3])) begin
          f.cls = alu_cls(code[5:3]);
          f.dst = 3'b111;
          f.src = code[2:0];
          if (code[2:0] == 3'b110) begin
            hit    = 1'b1;
            f.form = indexed ? FM_IDX : FM_MEM;
            need   = indexed ? ND_DISP : ND_NONE;
          end else if (!indexed) begin
            hit    = 1'b1;
            f.form = FM_REG;
          end
        end else if (code[7:6] == 2'b00 && code[3:0] == 4'b1001) begin
          hit    = 1'b1;
          f.cls  = OP_ADD16;
          f.pair = code[5:4];
          f.form = indexed ? FM_IDX : FM_REG;
        end else if (!indexed) begin
          if (code[7:6] == 2'b11 && code[2:0] == 3'b110 && alu_known(code[5:3])) begin
            hit    = 1'b1;
            f.cls  = alu_cls(code[5:3]);
            f.dst  = 3'b111;
            f.form = FM_IMM;
            need   = ND_IMM;
          end else if (code == 8'hCD) begin
            hit   = 1'b1;
            f.cls = OP_CALL;
            need  = ND_ADDR;
          end else if (code == 8'hC9) begin
            hit   = 1'b1;
            f.cls = OP_RET;
          end else if (code[7:6] == 2'b11 && code[3:0] == 4'b0101) begin
            hit    = 1'b1;
            f.cls  = OP_PUSH;
            f.pair = code[5:4];
          end else if (code[7:6] == 2'b11 && code[3:0] == 4'b0001) begin
            hit    = 1'b1;
            f.cls  = OP_POP;
            f.pair = code[5:4];
          end else if (code[7:6] == 2'b01 && code[5:3] != 3'b110 && code[2:0] != 3'b110) begin
            hit   = 1'b1;
            f.cls = OP_LD;
            f.dst = code[5:3];
            f.src = code[2:0];
          end else if (code == 8'h3F) begin
            hit   = 1'b1;
            f.cls = OP_CCF;
          end
        end
      end
      PG_BIT: begin
        if (code[7:6] == 2'b01) begin
          f.cls  = OP_BIT;
          f.bitn = code[5:3];
          f.src  = code[2:0];
          if (indexed) begin
            hit    = (code[2:0] == 3'b110);
            f.form = FM_IDX;
          end else begin
            hit    = 1'b1;
            f.form = (code[2:0] == 3'b110) ? FM_MEM : FM_REG;
          end
        end
      end
      PG_EXT: begin
        if (code[7:6] == 2'b01 && code[3:0] == 4'b1010) begin
          hit    = 1'b1;
          f.cls  = OP_ADC16;
          f.pair = code[5:4];
        end
      end
      default: hit = 1'b0;
    endcase
    illegal = !hit;
  end
endmodule

// File: rtl/idec_cycles.sv
module idec_cycles
  import idec_pkg::*;
(
  input  op_class_e        cls,
  input  form_e            form,
  output logic [CYC_W-1:0] cycles
);
  always_comb begin
    case (cls)
      OP_ADD, OP_ADC, OP_AND: begin
        case (form)
          FM_REG:  cycles = CY_ALU_REG;
          FM_IDX:  cycles = CY_ALU_IDX;
          default: cycles = CY_ALU_MEM;
        endcase
      end
      OP_BIT: begin
        case (form)
          FM_MEM:  cycles = CY_BIT_MEM;
          FM_IDX:  cycles = CY_BIT_IDX;
          default: cycles = CY_BIT_REG;
        endcase
      end
      OP_ADD16: cycles = (form == FM_IDX) ? CY_W16_IDX : CY_W16;
      OP_ADC16: cycles = CY_W16_IDX;
      OP_LD:    cycles = CY_ALU_REG;
      OP_CCF:   cycles = CY_ALU_REG;
      OP_PUSH:  cycles = CY_PUSH;
      OP_POP:   cycles = CY_POPRET;
      OP_RET:   cycles = CY_POPRET;
      OP_CALL:  cycles = CY_CALL;
      default:  cycles = '0;
    endcase
  end
endmodule

// File: rtl/idec_hold.sv
module idec_hold
  import idec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  result_t din,
  input  logic    out_ready,
  output logic    out_valid,
  output result_t dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import idec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_illegal,
  output logic [3:0]        out_class,
  output logic [2:0]        out_dst,
  output logic [2:0]        out_src,
  output logic [1:0]        out_pair,
  output logic              out_indexed,
  output logic              out_iy,
  output logic [2:0]        out_bit,
  output logic [LEN_W-1:0]  out_len,
  output logic [CYC_W-1:0]  out_cycles,
  output logic [BYTE_W-1:0] out_disp,
  output logic [DATA_W-1:0] out_data
);
  state_e            st, st_n;
  fields_t           cur, fld_n, c_f;
  logic              ix_q, iy_q, ix_n, iy_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [BYTE_W-1:0] disp_q, disp_n;
  logic [DATA_W-1:0] data_q, data_n;
  page_e             page;
  need_e             c_need;
  logic              c_idx, c_bitp, c_ext, c_ill;
  logic              decode_st, take, emit, ill;
  logic [CYC_W-1:0]  cyc;
  result_t           res_n, res;

  assign take = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;
  assign decode_st = (st == ST_OP) || (st == ST_XOP) || (st == ST_BIT) ||
                     (st == ST_XBIT) || (st == ST_EXT);

  always_comb begin
    case (st)
      ST_BIT, ST_XBIT: page = PG_BIT;
      ST_EXT:          page = PG_EXT;
      default:         page = PG_MAIN;
    endcase
  end

  idec_classify u_cls (
    .page       (page),
    .indexed    (ix_q),
    .code       (in_byte),
    .f          (c_f),
    .need       (c_need),
    .is_idx_pfx (c_idx),
    .is_bit_pfx (c_bitp),
    .is_ext_pfx (c_ext),
    .illegal    (c_ill)
  );

  always_comb begin
    fld_n  = cur;
    disp_n = disp_q;
    data_n = data_q;
    st_n   = st;
    ix_n   = ix_q;
    iy_n   = iy_q;
    emit   = 1'b0;
    ill    = 1'b0;
    len_n  = len_q + 1'b1;
    if (decode_st) begin
      if (c_ill) begin
        emit = 1'b1;
        ill  = 1'b1;
      end else if (c_idx) begin
        ix_n = 1'b1;
        iy_n = in_byte[5];
        st_n = ST_XOP;
      end else if (c_bitp) begin
        st_n = ix_q ? ST_XDISPB : ST_BIT;
      end else if (c_ext) begin
        st_n = ST_EXT;
      end else begin
        fld_n = c_f;
        case (c_need)
          ND_DISP: st_n = ST_DISP;
          ND_IMM:  st_n = ST_IMM;
          ND_ADDR: st_n = ST_ALO;
          default: emit = 1'b1;
        endcase
      end
    end else begin
      case (st)
        ST_DISP: begin
          disp_n = in_byte;
          emit   = 1'b1;
        end
        ST_XDISPB: begin
          disp_n = in_byte;
          st_n   = ST_XBIT;
        end
        ST_IMM: begin
          data_n = {{(DATA_W-BYTE_W){1'b0}}, in_byte};
          emit   = 1'b1;
        end
        ST_ALO: begin
          data_n[BYTE_W-1:0] = in_byte;
          st_n               = ST_AHI;
        end
        ST_AHI: begin
          data_n[DATA_W-1:BYTE_W] = in_byte;
          emit                    = 1'b1;
        end
        default: st_n = ST_OP;
      endcase
    end
  end

  idec_cycles u_cyc (
    .cls    (ill ? OP_ILL : fld_n.cls),
    .form   (fld_n.form),
    .cycles (cyc)
  );

  always_comb begin
    res_n     = '0;
    res_n.ill = ill;
    res_n.cls = OP_ILL;
    res_n.len = len_n;
    if (!ill) begin
      res_n.cls  = fld_n.cls;
      res_n.dst  = fld_n.dst;
      res_n.src  = fld_n.src;
      res_n.pair = fld_n.pair;
      res_n.bitn = fld_n.bitn;
      res_n.ix   = ix_n;
      res_n.iy   = iy_n;
      res_n.cyc  = cyc;
      res_n.disp = disp_n;
      res_n.data = data_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (take && emit)) begin
      st     <= ST_OP;
      cur    <= '0;
      ix_q   <= 1'b0;
      iy_q   <= 1'b0;
      len_q  <= '0;
      disp_q <= '0;
      data_q <= '0;
    end else if (take) begin
      st     <= st_n;
      cur    <= fld_n;
      ix_q   <= ix_n;
      iy_q   <= iy_n;
      len_q  <= len_n;
      disp_q <= disp_n;
      data_q <= data_n;
    end
  end

  idec_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take && emit),
    .din       (res_n),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .dout      (res)
  );

  assign out_illegal = res.ill;
  assign out_class   = res.cls;
  assign out_dst     = res.dst;
  assign out_src     = res.src;
  assign out_pair    = res.pair;
  assign out_indexed = res.ix;
  assign out_iy      = res.iy;
  assign out_bit     = res.bitn;
  assign out_len     = res.len;
  assign out_cycles  = res.cyc;
  assign out_disp    = res.disp;
  assign out_data    = res.data;
endmodule

// File: rtl/idec_chk.sv
module idec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_illegal,
  input logic [3:0]  out_class,
  input logic        out_indexed,
  input logic [2:0]  out_len,
  input logic [4:0]  out_cycles,
  input logic [15:0] out_data
);
  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_len) && $stable(out_data));

  // R12
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R11
  ill_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_class == 4'd15 && out_cycles == 5'd0);

  // R4
  idx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_indexed |-> out_len >= 3'd2 && !out_illegal);

  // R10
  call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 4'd9 |-> out_len == 3'd3 && out_cycles == 5'd17);
endmodule

bind insn_decoder idec_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_illegal (out_illegal),
  .out_class   (out_class),
  .out_indexed (out_indexed),
  .out_len     (out_len),
  .out_cycles  (out_cycles),
  .out_data    (out_data)
);

// File: tb/test_insn_decoder.sv
module test_insn_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_byte;
  logic        out_illegal, out_indexed, out_iy;
  logic [3:0]  out_class;
  logic [2:0]  out_dst, out_src, out_bit, out_len;
  logic [1:0]  out_pair;
  logic [4:0]  out_cycles;
  logic [7:0]  out_disp;
  logic [15:0] out_data;

  insn_decoder i_insn_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_illegal(out_illegal), .out_class(out_class), .out_dst(out_dst),
    .out_src(out_src), .out_pair(out_pair), .out_indexed(out_indexed),
    .out_iy(out_iy), .out_bit(out_bit), .out_len(out_len),
    .out_cycles(out_cycles), .out_disp(out_disp), .out_data(out_data)
  );

  int errors = 0;
  int checks = 0;
  bit bp_mode = 1'b0;
  bit gap_mode = 1'b0;
  logic [49:0] exp_q[$];
  string tag_q[$];

  wire [49:0] got = {out_illegal, out_class, out_dst, out_src, out_pair, out_indexed,
                     out_iy, out_bit, out_len, out_cycles, out_disp, out_data};

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [49:0] ref_of(input logic [7:0] b [4], input int n);
    logic       il = 1'b0, x = 1'b0, y = 1'b0;
    logic [3:0] c = 4'd0;
    logic [2:0] d = 3'd0, s = 3'd0, bt = 3'd0;
    logic [1:0] p = 2'd0;
    logic [4:0] cy = 5'd0;
    logic [7:0] ds = 8'd0, op, o2;
    logic [15:0] dt = 16'd0;
    int k = 0;
    if (b[0] == 8'hDD || b[0] == 8'hFD) begin
      x = 1'b1; y = (b[0] == 8'hFD); k = 1;
    end
    op = b[k];
    if (op == 8'hCB) begin
      o2 = x ? b[3] : b[1];
      if (o2[7:6] != 2'b01 || (x && o2[2:0] != 3'd6)) il = 1'b1;
      else begin
        c = 4'd3; bt = o2[5:3]; s = o2[2:0];
        if (x) begin ds = b[2]; cy = 5'd20; end
        else cy = (s == 3'd6) ? 5'd12 : 5'd8;
      end
    end else if (op == 8'hED && !x) begin
      if (b[1][7:6] == 2'b01 && b[1][3:0] == 4'hA) begin
        c = 4'd5; p = b[1][5:4]; cy = 5'd15;
      end else il = 1'b1;
    end else if (op[7:6] == 2'b10 && (op[5:3] == 3'd0 || op[5:3] == 3'd1 || op[5:3] == 3'd4)) begin
      c = (op[5:3] == 3'd4) ? 4'd2 : {1'b0, op[5:3]};
      d = 3'd7; s = op[2:0];
      if (s == 3'd6) begin
        if (x) begin ds = b[2]; cy = 5'd19; end else cy = 5'd7;
      end else if (x) il = 1'b1;
      else cy = 5'd4;
    end else if (op[7:6] == 2'b00 && op[3:0] == 4'd9) begin
      c = 4'd4; p = op[5:4]; cy = x ? 5'd15 : 5'd11;
    end else if (x) begin
      il = 1'b1;
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'd6 &&
                 (op[5:3] == 3'd0 || op[5:3] == 3'd1 || op[5:3] == 3'd4)) begin
      c = (op[5:3] == 3'd4) ? 4'd2 : {1'b0, op[5:3]};
      d = 3'd7; dt = {8'h00, b[1]}; cy = 5'd7;
    end else if (op == 8'hCD) begin
      c = 4'd9; dt = {b[2], b[1]}; cy = 5'd17;
    end else if (op == 8'hC9) begin
      c = 4'd10; cy = 5'd10;
    end else if (op[7:6] == 2'b11 && op[3:0] == 4'd5) begin
      c = 4'd7; p = op[5:4]; cy = 5'd11;
    end else if (op[7:6] == 2'b11 && op[3:0] == 4'd1) begin
      c = 4'd8; p = op[5:4]; cy = 5'd10;
    end else if (op[7:6] == 2'b01) begin
      if (op[5:3] == 3'd6 || op[2:0] == 3'd6) il = 1'b1;
      else begin c = 4'd6; d = op[5:3]; s = op[2:0]; cy = 5'd4; end
    end else if (op == 8'h3F) begin
      c = 4'd11; cy = 5'd4;
    end else il = 1'b1;
    if (il) return {1'b1, 4'd15, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 3'd0, n[2:0], 5'd0, 8'd0, 16'd0};
    return {1'b0, c, d, s, p, x, y, bt, n[2:0], cy, ds, dt};
  endfunction

  task automatic send(input string tag, input int n, input logic [7:0] b0,
                      input logic [7:0] b1 = 8'h00, input logic [7:0] b2 = 8'h00,
                      input logic [7:0] b3 = 8'h00);
    logic [7:0] bb [4];
    bb[0] = b0; bb[1] = b1; bb[2] = b2; bb[3] = b3;
    exp_q.push_back(ref_of(bb, n));
    tag_q.push_back(tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gap_mode && i != 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = bb[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    // R12: result present one cycle after the final byte transfers
    check(out_valid == 1'b1, "R12", "out_valid after final byte", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  logic        prev_hold = 1'b0;
  logic [49:0] prev_got = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      // R12: ready rule
      check(in_ready == (!out_valid || out_ready), "R12", "in_ready rule",
            {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
      if (prev_hold)
        check(out_valid && got == prev_got, "R12", "held result changed",
              {13'd0, out_valid, got}, {13'd0, 1'b1, prev_got});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R12", "unexpected result", {14'd0, got}, 64'd0);
        else begin
          logic [49:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, "decoded result", {14'd0, got}, {14'd0, e});
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_got  = got;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R12", "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(out_valid == 1'b0, "R1", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    for (int pass = 0; pass < 3; pass++) begin
      bp_mode  = (pass != 0);
      gap_mode = (pass == 2);
      send("R2", 1, 8'h80); send("R2", 1, 8'h8F); send("R2", 1, 8'hA5);
      send("R2", 1, 8'h86); send("R2", 1, 8'hA6); send("R2", 1, 8'h8E);
      send("R3", 2, 8'hC6, 8'h5A); send("R3", 2, 8'hCE, 8'hFF); send("R3", 2, 8'hE6, 8'h00);
      send("R4", 3, 8'hDD, 8'h86, 8'h05); send("R4", 3, 8'hFD, 8'h8E, 8'h80);
      send("R4", 3, 8'hDD, 8'hA6, 8'hFF);
      send("R5", 2, 8'hCB, 8'h47); send("R5", 2, 8'hCB, 8'h7E); send("R5", 2, 8'hCB, 8'h5A);
      send("R5", 4, 8'hDD, 8'hCB, 8'h10, 8'h46); send("R5", 4, 8'hFD, 8'hCB, 8'hF0, 8'h7E);
      send("R6", 1, 8'h09); send("R6", 1, 8'h39); send("R6", 2, 8'hDD, 8'h29);
      send("R6", 2, 8'hFD, 8'h19);
      send("R7", 2, 8'hED, 8'h4A); send("R7", 2, 8'hED, 8'h7A);
      send("R8", 1, 8'h41); send("R8", 1, 8'h7F); send("R8", 1, 8'h70);
      send("R8", 1, 8'h46); send("R8", 1, 8'h76);
      send("R9", 1, 8'hC5); send("R9", 1, 8'hF5); send("R9", 1, 8'hD1);
      send("R9", 1, 8'hF1); send("R9", 1, 8'hC9); send("R13", 1, 8'h3F);
      send("R10", 3, 8'hCD, 8'h34, 8'h12);
      send("R11", 2, 8'hDD, 8'hDD); send("R11", 2, 8'hDD, 8'h80);
      send("R11", 2, 8'hDD, 8'hC9); send("R11", 2, 8'hDD, 8'hED);
      send("R11", 2, 8'hED, 8'h00); send("R11", 2, 8'hCB, 8'h80);
      send("R11", 4, 8'hDD, 8'hCB, 8'h05, 8'h40); send("R11", 1, 8'h00);
      send("R11", 1, 8'hFF); send("R11", 4, 8'hFD, 8'hCB, 8'h05, 8'hC6);
      send("R11", 1, 8'h88);
    end

    bp_mode = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule